// File: doc/BRIEF.md
# Single-Bit Logic Control Processor Core

This core executes one 4-bit instruction per clock cycle. The instructions come from an external program store. The core holds a one-bit result register and two gating registers. The input gate decides whether reads from the data line are seen or forced to zero. The output gate decides whether stores may drive the data line and raise the write strobe.

The core has no program counter and no branch logic. Jump and return are reported to surrounding logic as one-cycle flag pulses. Two no-operation codes also raise their own marker pulses, so external logic can use them as hooks.

Conditional execution uses a two-state sequencer:
- **SEQ_RUN**: the current instruction executes.
- **SEQ_SKIP**: the current instruction is discarded.

Transitions between the states:
- **RUN→SKIP** happens on a return, or on skip-if-zero while the result is 0.
- **SKIP→RUN** always follows a discarded instruction.
- **RUN→RUN** covers every other executed instruction.
- Reset forces SEQ_RUN.

Top module: `bitctl_core`

## Requirements
- R1: Synchronous reset, active high (`rst`), clears the result, the input gate, the output gate and the skip state. While `rst` is 1, all four flags, `write_stb` and `data_oe` are 0.
- R2: Opcode 1 loads the gated data bit into the result. Opcode 2 loads its inverse.
- R3: Opcodes 3, 4, 5 and 6 set the result to result AND d, result AND NOT d, result OR d, and result OR NOT d. Here d is the gated data bit.
- R4: Opcode 7 sets the result to 1 when the result equals the gated data bit, and to 0 otherwise.
- R5: When the input gate is 0, the gated data bit is 0 for opcodes 1 to 7, whatever `data_in` is.
- R6: When the output gate is 1, opcode 8 drives the result and opcode 9 drives the inverted result. In that cycle `data_oe` and `write_stb` are 1. The result does not change.
- R7: When the output gate is 0, opcodes 8 and 9 leave `data_oe` and `write_stb` at 0.
- R8: Opcode A copies the raw `data_in` into the input gate. Opcode B copies the raw `data_in` into the output gate. Neither changes the result.
- R9: Opcode C raises `flag_jump` for its cycle. Opcode D raises `flag_return` for its cycle, and the next instruction is skipped.
- R10: Opcode E skips the next instruction when the result is 0, and has no effect when the result is 1.
- R11: A skipped instruction changes no register and produces no flag, strobe or drive. Skipping lasts exactly one instruction.
- R12: Opcode 0 raises only `flag_nop_o` and opcode F raises only `flag_nop_f`. Neither changes any register.
- R13: The opcode map is 0 nop-O, 1 load, 2 load-inverse, 3 AND, 4 AND-inverse, 5 OR, 6 OR-inverse, 7 XNOR, 8 store, 9 store-inverse, A set input gate, B set output gate, C jump, D return, E skip-if-zero, F nop-F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 4 | Instruction opcode for this cycle |
| data_in | input | 1 | Data line input value |
| data_out | output | 1 | Value driven onto the data line |
| data_oe | output | 1 | Data line drive enable |
| write_stb | output | 1 | Write pulse accompanying a store |
| result | output | 1 | Result register |
| flag_jump | output | 1 | Jump pulse |
| flag_return | output | 1 | Return pulse |
| flag_nop_o | output | 1 | Marker pulse for opcode 0 |
| flag_nop_f | output | 1 | Marker pulse for opcode F |

## Verification
A wrong result bit is visible on `result` one edge after the instruction that wrote it. The gate registers are not ports, so a corrupted gate only shows up later. It appears at the next store, through `data_oe` and `write_stb`, or at the next load, as a forced 0. The bench therefore follows each stimulus with a store and a load probe. A stuck or lost skip state shows up in the very next cycle, as a missing or extra flag or a result change that should not happen. A nop probe right after each tested instruction catches a skip that lasts too long.

// File: rtl/bitctl_pkg.sv
package bitctl_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOPO = 4'h0, OP_LD   = 4'h1, OP_LDC  = 4'h2, OP_AND  = 4'h3,
        OP_ANDC = 4'h4, OP_OR   = 4'h5, OP_ORC  = 4'h6, OP_XNOR = 4'h7,
        OP_STO  = 4'h8, OP_STOC = 4'h9, OP_IEN  = 4'hA, OP_OEN  = 4'hB,
        OP_JMP  = 4'hC, OP_RTN  = 4'hD, OP_SKZ  = 4'hE, OP_NOPF = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        FN_LOAD = 2'd0,
        FN_AND  = 2'd1,
        FN_OR   = 2'd2,
        FN_XNOR = 2'd3
    } logic_fn_e;

    typedef enum logic {
        SEQ_RUN  = 1'b0,
        SEQ_SKIP = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic      rr_we;
        logic_fn_e fn;
        logic      invert;
        logic      ien_we;
        logic      oen_we;
        logic      store;
        logic      jump;
        logic      ret;
        logic      skz;
        logic      nop_o;
        logic      nop_f;
    } ctrl_t;

endpackage

// File: rtl/bitctl_decode.sv
module bitctl_decode
    import bitctl_pkg::*;
(
    input  logic [OP_W-1:0] instr,
    output ctrl_t           ctrl
);
    opcode_e op;
    assign op = opcode_e'(instr);

    always_comb begin
        ctrl = '0;
        unique case (op)
            OP_NOPO: ctrl.nop_o = 1'b1;
            OP_LD:   begin ctrl.rr_we = 1'b1; ctrl.fn = FN_LOAD; end
            OP_LDC:  begin ctrl.rr_we = 1'b1; ctrl.fn = FN_LOAD; ctrl.invert = 1'b1; end
            OP_AND:  begin ctrl.rr_we = 1'b1; ctrl.fn = FN_AND; end
            OP_ANDC: begin ctrl.rr_we = 1'b1; ctrl.fn = FN_AND;  ctrl.invert = 1'b1; end
            OP_OR:   begin ctrl.rr_we = 1'b1; ctrl.fn = FN_OR; end
            OP_ORC:  begin ctrl.rr_we = 1'b1; ctrl.fn = FN_OR;   ctrl.invert = 1'b1; end
            OP_XNOR: begin ctrl.rr_we = 1'b1; ctrl.fn = FN_XNOR; end
            OP_STO:  ctrl.store = 1'b1;
            OP_STOC: begin ctrl.store = 1'b1; ctrl.invert = 1'b1; end
            OP_IEN:  ctrl.ien_we = 1'b1;
            OP_OEN:  ctrl.oen_we = 1'b1;
            OP_JMP:  ctrl.jump = 1'b1;
            OP_RTN:  ctrl.ret = 1'b1;
            OP_SKZ:  ctrl.skz = 1'b1;
            OP_NOPF: ctrl.nop_f = 1'b1;
        endcase
    end
endmodule

// File: rtl/bitctl_logic.sv
module bitctl_logic
    import bitctl_pkg::*;
(
    input  logic_fn_e fn,
    input  logic      invert,
    input  logic      rr,
    input  logic      din_gated,
    output logic      rr_next
);
    logic operand;
    assign operand = din_gated ^ invert;

    always_comb begin
        unique case (fn)
            FN_LOAD: rr_next = operand;
            FN_AND:  rr_next = rr & operand;
            FN_OR:   rr_next = rr | operand;
            FN_XNOR: rr_next = ~(rr ^ operand);
        endcase
    end
endmodule

// File: rtl/bitctl_seq.sv
module bitctl_seq
    import bitctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic want_skip,
    output logic execute,
    output logic skipping
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_RUN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = SEQ_RUN;
        execute  = 1'b0;
        skipping = 1'b0;
        unique case (state_q)
            SEQ_RUN: begin
                execute = 1'b1;
                if (want_skip) state_d = SEQ_SKIP;
            end
            SEQ_SKIP: begin
                skipping = 1'b1;
                state_d  = SEQ_RUN;
            end
        endcase
    end
endmodule

// File: rtl/bitctl_core.sv
module bitctl_core
    import bitctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] instr,
    input  logic            data_in,
    output logic            data_out,
    output logic            data_oe,
    output logic            write_stb,
    output logic            result,
    output logic            flag_jump,
    output logic            flag_return,
    output logic            flag_nop_o,
    output logic            flag_nop_f
);
    ctrl_t ctrl;
    logic  rr_q, ien_q, oen_q;
    logic  rr_next, din_gated;
    logic  execute, skip_q, live, drive;

    bitctl_decode u_dec (.instr(instr), .ctrl(ctrl));

    assign din_gated = data_in & ien_q;

    bitctl_logic u_logic (
        .fn(ctrl.fn), .invert(ctrl.invert), .rr(rr_q),
        .din_gated(din_gated), .rr_next(rr_next)
    );

    bitctl_seq u_seq (
        .clk(clk), .rst(rst),
        .want_skip(ctrl.ret | (ctrl.skz & ~rr_q)),
        .execute(execute), .skipping(skip_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q  <= 1'b0;
            ien_q <= 1'b0;
            oen_q <= 1'b0;
        end else if (execute) begin
            if (ctrl.rr_we)  rr_q  <= rr_next;
            if (ctrl.ien_we) ien_q <= data_in;
            if (ctrl.oen_we) oen_q <= data_in;
        end
    end

    assign live        = execute & ~rst;
    assign drive       = live & ctrl.store & oen_q;
    assign data_oe     = drive;
    assign write_stb   = drive;
    assign data_out    = drive & (rr_q ^ ctrl.invert);
    assign result      = rr_q;
    assign flag_jump   = live & ctrl.jump;
    assign flag_return = live & ctrl.ret;
    assign flag_nop_o  = live & ctrl.nop_o;
    assign flag_nop_f  = live & ctrl.nop_f;
endmodule

// File: rtl/bitctl_core_chk.sv
module bitctl_core_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] instr,
    input logic       data_in,
    input logic       data_oe,
    input logic       write_stb,
    input logic       result,
    input logic       flag_jump,
    input logic       flag_return,
    input logic       flag_nop_o,
    input logic       flag_nop_f,
    input logic       skip_q,
    input logic       ien_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (!result && !skip_q));

    // R6
    strobe_with_drive_chk: assert property (@(posedge clk) disable iff (rst)
        write_stb |-> data_oe);

    // R6
    store_keeps_result_chk: assert property (@(posedge clk) disable iff (rst)
        write_stb |=> $stable(result));

    // R12
    one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flag_jump, flag_return, flag_nop_o, flag_nop_f, write_stb}));

    // R4
    xnor_update_chk: assert property (@(posedge clk) disable iff (rst)
        (!skip_q && instr == 4'h7 && ien_q) |=> (result == ($past(result) == $past(data_in))));

    // R9
    return_skips_chk: assert property (@(posedge clk) disable iff (rst)
        flag_return |=> skip_q);

    // R10
    skz_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!skip_q && instr == 4'hE && !result) |=> skip_q);

    // R11
    skip_silent_chk: assert property (@(posedge clk) disable iff (rst)
        skip_q |-> !(flag_jump || flag_return || flag_nop_o || flag_nop_f || data_oe));

    // R11
    skip_single_chk: assert property (@(posedge clk) disable iff (rst)
        skip_q |=> (!skip_q && $stable(result)));
endmodule

bind bitctl_core bitctl_core_chk u_chk (
    .clk(clk), .rst(rst), .instr(instr), .data_in(data_in),
    .data_oe(data_oe), .write_stb(write_stb), .result(result),
    .flag_jump(flag_jump), .flag_return(flag_return),
    .flag_nop_o(flag_nop_o), .flag_nop_f(flag_nop_f),
    .skip_q(skip_q), .ien_q(ien_q)
);

// File: tb/bitctl_core_tb.sv
module bitctl_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] instr = 4'h0;
    logic       data_in = 1'b0;
    logic       data_out, data_oe, write_stb, result;
    logic       flag_jump, flag_return, flag_nop_o, flag_nop_f;

    int total = 0;
    int fails = 0;

    // model state
    logic m_rr, m_ien, m_oen, m_skip;

    always #10 clk = ~clk;

    bitctl_core u_dut (
        .clk(clk), .rst(rst), .instr(instr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .write_stb(write_stb),
        .result(result), .flag_jump(flag_jump), .flag_return(flag_return),
        .flag_nop_o(flag_nop_o), .flag_nop_f(flag_nop_f)
    );

    // R13 opcode values used below: 0 nopO,1 ld,2 ldc,3 and,4 andc,5 or,
    // 6 orc,7 xnor,8 sto,9 stoc,A ien,B oen,C jmp,D rtn,E skz,F nopF
    function automatic string req_of(input logic [3:0] op, input logic sk, input logic ie);
        if (sk) return "R11";
        if (op >= 4'h1 && op <= 4'h7 && !ie) return "R5";
        case (op)
            4'h0, 4'hF: return "R12";
            4'h1, 4'h2: return "R2";
            4'h3, 4'h4, 4'h5, 4'h6: return "R3";
            4'h7: return "R4";
            4'h8, 4'h9: return "R6/R7";
            4'hA, 4'hB: return "R8";
            4'hC, 4'hD: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%h actual=%b expected=%b", req, instr, act, exp);
        end
    endtask

    task automatic model_reset();
        m_rr = 1'b0; m_ien = 1'b0; m_oen = 1'b0; m_skip = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; instr = 4'hC; data_in = 1'b1;
        #2;
        // R1 outputs quiet during reset
        check("R1", {3'b0, flag_jump, flag_return, flag_nop_o, flag_nop_f, write_stb | data_oe}, 8'h00);
        @(negedge clk);
        rst = 1'b0; instr = 4'h0; data_in = 1'b0;
        model_reset();
    endtask

    task automatic step(input logic [3:0] op, input logic d);
        logic ex, e_oe, e_out, eff, nrr, nskip;
        string req;
        ex = !m_skip;
        req = req_of(op, m_skip, m_ien);
        e_oe = ex && (op == 4'h8 || op == 4'h9) && m_oen;
        e_out = e_oe ? (op == 4'h8 ? m_rr : !m_rr) : 1'b0;
        @(negedge clk);
        instr = op; data_in = d;
        #2;
        check(req, {1'b0, flag_jump, flag_return, flag_nop_o, flag_nop_f, write_stb, data_oe, data_oe & data_out},
              {1'b0, ex && op == 4'hC, ex && op == 4'hD, ex && op == 4'h0, ex && op == 4'hF, e_oe, e_oe, e_out});
        eff = d & m_ien;
        nrr = m_rr;
        nskip = 1'b0;
        if (ex) begin
            case (op)
                4'h1: nrr = eff;
                4'h2: nrr = !eff;
                4'h3: nrr = m_rr & eff;
                4'h4: nrr = m_rr & !eff;
                4'h5: nrr = m_rr | eff;
                4'h6: nrr = m_rr | !eff;
                4'h7: nrr = (m_rr == eff);
                4'hA: m_ien = d;
                4'hB: m_oen = d;
                default: ;
            endcase
            nskip = (op == 4'hD) || (op == 4'hE && !m_rr);
        end
        m_rr = nrr;
        m_skip = nskip;
        @(posedge clk);
        #2;
        check(req, {7'b0, result}, {7'b0, m_rr});
    endtask

    logic done = 1'b0;

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state and quiet outputs
        check("R1", {6'b0, result, flag_jump | flag_return | flag_nop_o | flag_nop_f | write_stb | data_oe}, 8'h00);
        do_reset();
        // R1 reset clears a pending skip: rtn, reset, then nopO must flag
        step(4'hD, 1'b0);
        do_reset();
        step(4'h0, 1'b0);
        // exhaustive sweep
        for (int sk = 0; sk < 2; sk++)
            for (int ie = 0; ie < 2; ie++)
                for (int oe = 0; oe < 2; oe++)
                    for (int r = 0; r < 2; r++)
                        for (int op = 0; op < 16; op++)
                            for (int d = 0; d < 2; d++) begin
                                do_reset();
                                step(4'hA, 1'b1);
                                step(4'h1, r[0]);
                                step(4'hB, oe[0]);
                                step(4'hA, ie[0]);
                                if (sk != 0) step(4'hD, 1'b0);
                                step(op[3:0], d[0]);
                                step(4'h0, 1'b0);   // catches lingering skip
                                step(4'h8, 1'b0);   // exposes output gate and result
                                step(4'h1, 1'b1);   // exposes input gate
                            end
        // R10 skip-if-zero with result 1 followed by jump
        do_reset();
        step(4'hA, 1'b1);
        step(4'h1, 1'b1);
        step(4'hE, 1'b0);
        step(4'hC, 1'b0);
        step(4'h2, 1'b1);
        step(4'hE, 1'b0);
        step(4'hC, 1'b0);
        step(4'hF, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule